// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block steps a device-to-memory or memory-to-device transfer through the segments that a descriptor-driven DMA channel hands over one at a time. A start pulse arms it with the drive kind (hard disk or packet-addressed optical drive), a command, a sector or block address and a size. It then keeps a signed count of bytes still owed and an unsigned running index. For every segment it either issues one request to the storage side, closes the current segment only, or closes the whole transfer.

Hard-disk transfers address the device in 512-byte sectors. Packet transfers address it in 2048-byte blocks. A packet transfer whose block address is all ones carries no media data: it copies a reply buffer straight into memory. Segment-end and transfer-end are reported separately, so the channel always gets its segment handed back. Only a transfer-end raises the completion strobe and its status code.

Top module: `dma_xfer_seq`

## Requirements
- R1: A start pulse accepted while no segment is in progress sets `active_o`, clears the running index and loads the remaining count with `nsec_i`×512 when `pkt_mode_i`=0, or with `pkt_bytes_i` when `pkt_mode_i`=1.
- R2: In hard-disk mode a request carries `req_offset_o` = start sector×512 + running index.
- R3: In packet mode a request carries `req_offset_o` = block address×2048 + running index.
- R4: A segment offered while `active_o` is low is not taken: `seg_busy_o`, `seg_done_o` and `req_valid_o` stay low. The same segment is taken once a later start sets `active_o`.
- R5: When a segment is evaluated with a remaining count of zero or less, the transfer ends. `done_o` and `seg_done_o` pulse together, `active_o` drops, and `done_status_o` is 0 (ready and seek complete) for a hard disk or 1 (packet command success) for packet mode.
- R6: A zero-length segment evaluated while bytes remain pulses `seg_done_o` only. `done_o` stays low, `active_o` stays high and the index is unchanged.
- R7: Each issued request carries the segment length in `req_len_o` and the segment address in `req_addr_o`. It subtracts that length from the remaining count and adds it to the index. After the acknowledge, the segment is evaluated again as zero-length.
- R8: In packet mode with an all-ones block address, one request of kind 3 (buffer copy) with length min(remaining, segment length) is issued. Its acknowledge ends the transfer with status 1 and drops `active_o`.
- R9: An acknowledge with `req_err_i` high ends the transfer with status 2, drops `active_o` and still pulses `seg_done_o`.
- R10: The request kind is 0 (device to memory) for command 0 and for every packet transfer, 1 (memory to device) for command 1, and 2 (trim) for command 2. Command 3 in hard-disk mode is illegal: no request is issued, and the transfer ends with status 3.
- R11: While `req_valid_o` is high and not yet acknowledged, kind, offset, address and length hold steady.
- R12: A start pulse that arrives while a segment is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Arm a new transfer |
| pkt_mode_i | input | 1 | 0 hard disk, 1 packet drive |
| cmd_i | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| nsec_i | input | NSECW | Sector count for hard-disk mode |
| pkt_bytes_i | input | CNTW | Byte size for packet mode |
| lba_i | input | LBAW | Start sector or block address |
| seg_valid_i | input | 1 | Channel offers a segment (held until `seg_done_o`) |
| seg_addr_i | input | ADDRW | Segment memory address |
| seg_len_i | input | CNTW | Segment length in bytes |
| seg_busy_o | output | 1 | A segment is being worked on |
| seg_done_o | output | 1 | Segment handed back to the channel |
| req_valid_o | output | 1 | Storage request pending |
| req_kind_o | output | 2 | 0 dev→mem, 1 mem→dev, 2 trim, 3 buffer copy |
| req_offset_o | output | OFFW | Device byte offset |
| req_addr_o | output | ADDRW | Memory address |
| req_len_o | output | CNTW | Byte length |
| req_ack_i | input | 1 | Request finished |
| req_err_i | input | 1 | Request failed (with `req_ack_i`) |
| active_o | output | 1 | Transfer armed |
| done_o | output | 1 | Transfer-end strobe |
| done_status_o | output | 2 | 0 disk ok, 1 packet ok, 2 error, 3 illegal command |

## Verification
A segment taken at a clock edge sets `seg_busy_o` in the following cycle. A request, a segment-end or a transfer-end becomes visible one edge after that. An acknowledge of a media request is followed two edges later by `seg_done_o` and, if the count is spent, `done_o`. A copy or error acknowledge takes only one edge. The bench drives inputs on falling edges and reads outputs on the next falling edge, polling within a bounded loop. It never assumes a fixed count, so acknowledge delays of zero and several cycles both land on the right sample. Start outcomes are judged through what follows: offsets, whether a segment-end comes with or without `done_o`, and the status code.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  typedef enum logic [1:0] {
    RK_READ  = 2'd0,
    RK_WRITE = 2'd1,
    RK_TRIM  = 2'd2,
    RK_COPY  = 2'd3
  } req_kind_t;

  typedef enum logic [1:0] {
    CPL_DISK_OK = 2'd0,
    CPL_PKT_OK  = 2'd1,
    CPL_ERR     = 2'd2,
    CPL_ILLEGAL = 2'd3
  } cpl_t;

  localparam logic [1:0] CMD_READ  = 2'd0;
  localparam logic [1:0] CMD_WRITE = 2'd1;
  localparam logic [1:0] CMD_TRIM  = 2'd2;
  localparam logic [1:0] CMD_BAD   = 2'd3;
endpackage

// File: rtl/dxs_offset.sv
module dxs_offset #(
  parameter int LBAW      = 32,
  parameter int CNTW      = 32,
  parameter int OFFW      = 48,
  parameter int SEC_SHIFT = 9,
  parameter int BLK_SHIFT = 11
) (
  input  logic            pkt_mode_i,
  input  logic [LBAW-1:0] lba_i,
  input  logic [CNTW-1:0] idx_i,
  output logic [OFFW-1:0] offset_o
);
  localparam int LPAD = OFFW - LBAW;
  localparam int IPAD = OFFW - CNTW;

  function automatic logic [OFFW-1:0] dev_byte(input logic pkt,
                                               input logic [LBAW-1:0] lba,
                                               input logic [CNTW-1:0] idx);
    logic [OFFW-1:0] base;
    base = {{LPAD{1'b0}}, lba};
    base = pkt ? (base << BLK_SHIFT) : (base << SEC_SHIFT);
    return base + {{IPAD{1'b0}}, idx};
  endfunction

  assign offset_o = dev_byte(pkt_mode_i, lba_i, idx_i);
endmodule

// File: rtl/dxs_counters.sv
module dxs_counters #(
  parameter int CNTW      = 32,
  parameter int NSECW     = 16,
  parameter int SEC_SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             pkt_mode_i,
  input  logic [NSECW-1:0] nsec_i,
  input  logic [CNTW-1:0]  pkt_bytes_i,
  input  logic             consume_i,
  input  logic [CNTW-1:0]  seg_len_i,
  output logic [CNTW-1:0]  idx_o,
  output logic             exhausted_o,
  output logic [CNTW-1:0]  copy_len_o
);
  localparam int NPAD = CNTW - NSECW;

  logic signed [CNTW-1:0] rem_q;
  logic [CNTW-1:0]        idx_q;
  logic [CNTW-1:0]        sum_w;

  function automatic logic [CNTW-1:0] initial_count(input logic pkt,
                                                    input logic [NSECW-1:0] nsec,
                                                    input logic [CNTW-1:0] pbytes);
    return pkt ? pbytes : ({{NPAD{1'b0}}, nsec} << SEC_SHIFT);
  endfunction

  function automatic logic [CNTW-1:0] smaller(input logic [CNTW-1:0] a,
                                              input logic [CNTW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      rem_q <= $signed(initial_count(pkt_mode_i, nsec_i, pkt_bytes_i));
      idx_q <= '0;
    end else if (consume_i) begin
      rem_q <= rem_q - $signed(seg_len_i);
      idx_q <= idx_q + seg_len_i;
    end
  end

  assign idx_o       = idx_q;
  assign exhausted_o = rem_q[CNTW-1] || (rem_q == '0);
  assign copy_len_o  = smaller($unsigned(rem_q), seg_len_i);
  assign sum_w       = $unsigned(rem_q) + idx_q;

  // R1: a load clears the running index
  p_load_clears_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (idx_q == '0));

  // R7: consuming moves bytes from remaining to index, the total is conserved
  p_consume_conserves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_i && !load_i) |=> (sum_w == $past(sum_w)));
endmodule

// File: rtl/dxs_fsm.sv
module dxs_fsm
  import dxs_pkg::*;
#(
  parameter int LBAW  = 32,
  parameter int CNTW  = 32,
  parameter int ADDRW = 32,
  parameter int OFFW  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pkt_mode_i,
  input  logic [1:0]       cmd_i,
  input  logic [LBAW-1:0]  lba_i,
  input  logic             seg_valid_i,
  input  logic [ADDRW-1:0] seg_addr_i,
  input  logic [CNTW-1:0]  seg_len_i,
  input  logic             req_ack_i,
  input  logic             req_err_i,
  input  logic             exhausted_i,
  input  logic [CNTW-1:0]  copy_len_i,
  input  logic [OFFW-1:0]  dev_offset_i,
  output logic             load_o,
  output logic             consume_o,
  output logic [CNTW-1:0]  cur_len_o,
  output logic             pkt_q_o,
  output logic [LBAW-1:0]  lba_q_o,
  output logic             seg_busy_o,
  output logic             seg_done_o,
  output logic             req_valid_o,
  output logic [1:0]       req_kind_o,
  output logic [OFFW-1:0]  req_offset_o,
  output logic [ADDRW-1:0] req_addr_o,
  output logic [CNTW-1:0]  req_len_o,
  output logic             active_o,
  output logic             done_o,
  output logic [1:0]       done_status_o
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_REQ, S_END} st_t;

  st_t              st_q;
  logic             act_q, pkt_q, fin_q, copy_q;
  logic [1:0]       cmd_q;
  logic [LBAW-1:0]  lba_q;
  logic [ADDRW-1:0] seg_addr_q;
  logic [CNTW-1:0]  seg_len_q;
  logic [OFFW-1:0]  req_off_q;
  logic [CNTW-1:0]  req_len_q;
  req_kind_t        rk_q;
  cpl_t             sts_q;

  // named events for checking
  logic take_start, take_seg, at_eval, len_zero, raw_copy;
  logic ev_finish, ev_segend, ev_copy, ev_bad, ev_issue;
  logic ack_err, ack_ok;

  function automatic req_kind_t kind_of(input logic pkt, input logic [1:0] cmd);
    if (pkt)              return RK_READ;
    if (cmd == CMD_WRITE) return RK_WRITE;
    if (cmd == CMD_TRIM)  return RK_TRIM;
    return RK_READ;
  endfunction

  assign take_start = start_i && (st_q == S_IDLE);
  assign take_seg   = (st_q == S_IDLE) && !start_i && act_q && seg_valid_i;
  assign at_eval    = (st_q == S_EVAL);
  assign len_zero   = (seg_len_q == '0);
  assign raw_copy   = pkt_q && (&lba_q);
  assign ev_finish  = exhausted_i;
  assign ev_segend  = !exhausted_i && len_zero;
  assign ev_copy    = !exhausted_i && !len_zero && raw_copy;
  assign ev_bad     = !exhausted_i && !len_zero && !pkt_q && (cmd_q == CMD_BAD);
  assign ev_issue   = !exhausted_i && !len_zero && !raw_copy && !ev_bad;
  assign ack_err    = (st_q == S_REQ) && req_ack_i && req_err_i;
  assign ack_ok     = (st_q == S_REQ) && req_ack_i && !req_err_i;

  assign load_o    = take_start;
  assign consume_o = at_eval && ev_issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      act_q      <= 1'b0;
      pkt_q      <= 1'b0;
      fin_q      <= 1'b0;
      copy_q     <= 1'b0;
      cmd_q      <= CMD_READ;
      lba_q      <= '0;
      seg_addr_q <= '0;
      seg_len_q  <= '0;
      req_off_q  <= '0;
      req_len_q  <= '0;
      rk_q       <= RK_READ;
      sts_q      <= CPL_DISK_OK;
    end else begin
      case (st_q)
        S_IDLE: begin
          fin_q <= 1'b0;
          if (take_start) begin
            act_q <= 1'b1;
            pkt_q <= pkt_mode_i;
            cmd_q <= cmd_i;
            lba_q <= lba_i;
          end else if (take_seg) begin
            seg_addr_q <= seg_addr_i;
            seg_len_q  <= seg_len_i;
            st_q       <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (ev_finish) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
            sts_q <= pkt_q ? CPL_PKT_OK : CPL_DISK_OK;
            st_q  <= S_END;
          end else if (ev_segend) begin
            fin_q <= 1'b0;
            st_q  <= S_END;
          end else if (ev_copy) begin
            req_off_q <= '0;
            req_len_q <= copy_len_i;
            rk_q      <= RK_COPY;
            copy_q    <= 1'b1;
            st_q      <= S_REQ;
          end else if (ev_bad) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
            sts_q <= CPL_ILLEGAL;
            st_q  <= S_END;
          end else begin
            req_off_q <= dev_offset_i;
            req_len_q <= seg_len_q;
            rk_q      <= kind_of(pkt_q, cmd_q);
            copy_q    <= 1'b0;
            st_q      <= S_REQ;
          end
        end
        S_REQ: begin
          if (ack_err) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
            sts_q <= CPL_ERR;
            st_q  <= S_END;
          end else if (ack_ok && copy_q) begin
            act_q <= 1'b0;
            fin_q <= 1'b1;
            sts_q <= CPL_PKT_OK;
            st_q  <= S_END;
          end else if (ack_ok) begin
            seg_len_q <= '0;
            st_q      <= S_EVAL;
          end
        end
        default: begin
          fin_q <= 1'b0;
          st_q  <= S_IDLE;
        end
      endcase
    end
  end

  assign cur_len_o     = seg_len_q;
  assign pkt_q_o       = pkt_q;
  assign lba_q_o       = lba_q;
  assign seg_busy_o    = (st_q != S_IDLE);
  assign seg_done_o    = (st_q == S_END);
  assign req_valid_o   = (st_q == S_REQ);
  assign req_kind_o    = rk_q;
  assign req_offset_o  = req_off_q;
  assign req_addr_o    = seg_addr_q;
  assign req_len_o     = req_len_q;
  assign active_o      = act_q;
  assign done_o        = (st_q == S_END) && fin_q;
  assign done_status_o = sts_q;

  // R4: an idle, unarmed sequencer never starts work on a segment
  p_no_take_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_IDLE) && !act_q) |=> (st_q == S_IDLE));

  // R5: a transfer-end strobe always comes with the armed flag cleared
  p_done_drops_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!active_o && seg_done_o));

  // R6: zero length with bytes left closes the segment only
  p_zero_len_segment_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_eval && ev_segend) |=> (seg_done_o && !done_o && active_o));

  // R9: a failed acknowledge ends with the error code
  p_error_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ack_i && req_err_i) |=> (done_o && done_status_o == CPL_ERR));

  // R10: an illegal command issues no request
  p_illegal_no_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (at_eval && ev_bad) |=> (!req_valid_o && done_status_o == CPL_ILLEGAL));

  // R11: request held steady until acknowledged
  p_request_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_offset_o) &&
      $stable(req_len_o) && $stable(req_kind_o) && $stable(req_addr_o)));

  // R12: a start during segment work leaves the armed flag alone
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && seg_busy_o) |=> $stable(active_o));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int LBAW      = 32,
  parameter int CNTW      = 32,
  parameter int NSECW     = 16,
  parameter int ADDRW     = 32,
  parameter int OFFW      = 48,
  parameter int SEC_SHIFT = 9,
  parameter int BLK_SHIFT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pkt_mode_i,
  input  logic [1:0]       cmd_i,
  input  logic [NSECW-1:0] nsec_i,
  input  logic [CNTW-1:0]  pkt_bytes_i,
  input  logic [LBAW-1:0]  lba_i,
  input  logic             seg_valid_i,
  input  logic [ADDRW-1:0] seg_addr_i,
  input  logic [CNTW-1:0]  seg_len_i,
  output logic             seg_busy_o,
  output logic             seg_done_o,
  output logic             req_valid_o,
  output logic [1:0]       req_kind_o,
  output logic [OFFW-1:0]  req_offset_o,
  output logic [ADDRW-1:0] req_addr_o,
  output logic [CNTW-1:0]  req_len_o,
  input  logic             req_ack_i,
  input  logic             req_err_i,
  output logic             active_o,
  output logic             done_o,
  output logic [1:0]       done_status_o
);
  logic            load_w, consume_w, exhausted_w, pkt_q_w;
  logic [CNTW-1:0] idx_w, copy_len_w, cur_len_w;
  logic [LBAW-1:0] lba_q_w;
  logic [OFFW-1:0] dev_off_w;

  dxs_counters #(.CNTW(CNTW), .NSECW(NSECW), .SEC_SHIFT(SEC_SHIFT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .pkt_mode_i (pkt_mode_i),
    .nsec_i     (nsec_i),
    .pkt_bytes_i(pkt_bytes_i),
    .consume_i  (consume_w),
    .seg_len_i  (cur_len_w),
    .idx_o      (idx_w),
    .exhausted_o(exhausted_w),
    .copy_len_o (copy_len_w)
  );

  dxs_offset #(.LBAW(LBAW), .CNTW(CNTW), .OFFW(OFFW),
               .SEC_SHIFT(SEC_SHIFT), .BLK_SHIFT(BLK_SHIFT)) u_off (
    .pkt_mode_i(pkt_q_w),
    .lba_i     (lba_q_w),
    .idx_i     (idx_w),
    .offset_o  (dev_off_w)
  );

  dxs_fsm #(.LBAW(LBAW), .CNTW(CNTW), .ADDRW(ADDRW), .OFFW(OFFW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pkt_mode_i   (pkt_mode_i),
    .cmd_i        (cmd_i),
    .lba_i        (lba_i),
    .seg_valid_i  (seg_valid_i),
    .seg_addr_i   (seg_addr_i),
    .seg_len_i    (seg_len_i),
    .req_ack_i    (req_ack_i),
    .req_err_i    (req_err_i),
    .exhausted_i  (exhausted_w),
    .copy_len_i   (copy_len_w),
    .dev_offset_i (dev_off_w),
    .load_o       (load_w),
    .consume_o    (consume_w),
    .cur_len_o    (cur_len_w),
    .pkt_q_o      (pkt_q_w),
    .lba_q_o      (lba_q_w),
    .seg_busy_o   (seg_busy_o),
    .seg_done_o   (seg_done_o),
    .req_valid_o  (req_valid_o),
    .req_kind_o   (req_kind_o),
    .req_offset_o (req_offset_o),
    .req_addr_o   (req_addr_o),
    .req_len_o    (req_len_o),
    .active_o     (active_o),
    .done_o       (done_o),
    .done_status_o(done_status_o)
  );
endmodule

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, pkt_mode_i = 0, seg_valid_i = 0, req_ack_i = 0, req_err_i = 0;
  logic [1:0]  cmd_i = 0;
  logic [15:0] nsec_i = 0;
  logic [31:0] pkt_bytes_i = 0, lba_i = 0, seg_addr_i = 0, seg_len_i = 0;
  logic seg_busy_o, seg_done_o, req_valid_o, active_o, done_o;
  logic [1:0]  req_kind_o, done_status_o;
  logic [47:0] req_offset_o;
  logic [31:0] req_addr_o, req_len_o;

  int checks = 0, failures = 0;

  // observation results of one segment
  int          n_req;
  logic [47:0] last_off;
  logic [31:0] last_len, last_addr;
  logic [1:0]  last_kind, seen_status;
  bit          seen_done, seen_sd, seen_busy, hold_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pkt_mode_i(pkt_mode_i),
    .cmd_i(cmd_i), .nsec_i(nsec_i), .pkt_bytes_i(pkt_bytes_i), .lba_i(lba_i),
    .seg_valid_i(seg_valid_i), .seg_addr_i(seg_addr_i), .seg_len_i(seg_len_i),
    .seg_busy_o(seg_busy_o), .seg_done_o(seg_done_o), .req_valid_o(req_valid_o),
    .req_kind_o(req_kind_o), .req_offset_o(req_offset_o), .req_addr_o(req_addr_o),
    .req_len_o(req_len_o), .req_ack_i(req_ack_i), .req_err_i(req_err_i),
    .active_o(active_o), .done_o(done_o), .done_status_o(done_status_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic arm(input logic pkt, input logic [1:0] cmd, input logic [15:0] nsec,
                     input logic [31:0] pbytes, input logic [31:0] lba);
    @(negedge clk);
    pkt_mode_i = pkt; cmd_i = cmd; nsec_i = nsec; pkt_bytes_i = pbytes; lba_i = lba;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // offer a segment, answer requests after dly cycles, wait for the segment end
  task automatic run_seg(input logic [31:0] a, input logic [31:0] l, input bit err,
                         input int dly, input bit poke);
    int wait_cnt = 0;
    n_req = 0; seen_done = 0; seen_sd = 0; seen_busy = 0; hold_bad = 0;
    @(negedge clk);
    seg_valid_i = 1'b1; seg_addr_i = a; seg_len_i = l;
    for (int c = 0; c < 80 && !seen_sd; c++) begin
      @(negedge clk);
      req_ack_i = 1'b0; req_err_i = 1'b0; start_i = 1'b0;
      if (seg_busy_o) seen_busy = 1;
      if (seg_done_o) begin
        seen_sd = 1; seen_done = done_o; seen_status = done_status_o;
        seg_valid_i = 1'b0;
      end else if (req_valid_o) begin
        if (wait_cnt > 0 && (req_offset_o != last_off || req_len_o != last_len ||
                             req_kind_o != last_kind || req_addr_o != last_addr))
          hold_bad = 1;
        last_off = req_offset_o; last_len = req_len_o;
        last_kind = req_kind_o; last_addr = req_addr_o;
        if (poke && wait_cnt == 1) begin
          nsec_i = 16'd0; start_i = 1'b1;
        end
        if (wait_cnt >= dly) begin
          n_req++; req_ack_i = 1'b1; req_err_i = err; wait_cnt = 0;
        end else wait_cnt++;
      end
    end
    check(seen_sd, "R7", "segment end seen", 64'(seen_sd), 64'd1);
  endtask

  typedef struct packed {
    logic        pkt;
    logic [1:0]  cmd;
    logic [15:0] nsec;
    logic [31:0] pbytes;
    logic [31:0] lba;
    logic [31:0] len;
    logic [1:0]  ekind;
    logic [1:0]  estat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'd1, 32'd0,    32'd10,         32'd512,  2'd0, 2'd0},
    '{1'b0, 2'd1, 16'd2, 32'd0,    32'h100,        32'd1024, 2'd1, 2'd0},
    '{1'b0, 2'd2, 16'd1, 32'd0,    32'd7,          32'd512,  2'd2, 2'd0},
    '{1'b1, 2'd0, 16'd0, 32'd2048, 32'd5,          32'd2048, 2'd0, 2'd1},
    '{1'b1, 2'd3, 16'd0, 32'd4096, 32'h12345,      32'd4096, 2'd0, 2'd1},
    '{1'b0, 2'd0, 16'd1, 32'd0,    32'hFFFF_FFFF,  32'd512,  2'd0, 2'd0}
  };

  function automatic logic [47:0] exp_offset(input logic pkt, input logic [31:0] lba,
                                             input logic [31:0] idx);
    logic [47:0] unit;
    unit = pkt ? 48'd2048 : 48'd512;
    return 48'(lba) * unit + 48'(idx);
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!active_o && !req_valid_o && !seg_busy_o && !done_o && !seg_done_o,
          "R1", "reset state quiet", {59'd0, active_o, req_valid_o, seg_busy_o, done_o, seg_done_o}, 64'd0);

    // R4: segment offered before arming is left alone
    seg_valid_i = 1'b1; seg_addr_i = 32'h40; seg_len_i = 32'd512;
    seen_busy = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (seg_busy_o || req_valid_o || seg_done_o) seen_busy = 1;
    end
    check(!seen_busy, "R4", "unarmed segment not taken", 64'(seen_busy), 64'd0);
    arm(1'b0, 2'd0, 16'd1, 32'd0, 32'd3);
    check(active_o, "R1", "start sets active", 64'(active_o), 64'd1);
    run_seg(32'h40, 32'd512, 1'b0, 0, 1'b0);
    check(n_req == 1 && last_off == exp_offset(1'b0, 32'd3, 32'd0), "R4",
          "restarted segment consumed", 64'(last_off), 64'(exp_offset(1'b0, 32'd3, 32'd0)));

    // table of single-segment transfers
    for (int v = 0; v < NV; v++) begin
      arm(VECS[v].pkt, VECS[v].cmd, VECS[v].nsec, VECS[v].pbytes, VECS[v].lba);
      run_seg(32'h1000 + 32'(v) * 32'h100, VECS[v].len, 1'b0, v % 3, 1'b0);
      check(n_req == 1, "R7", "one request", 64'(n_req), 64'd1);
      check(last_off == exp_offset(VECS[v].pkt, VECS[v].lba, 32'd0),
            VECS[v].pkt ? "R3" : "R2", "offset", 64'(last_off),
            64'(exp_offset(VECS[v].pkt, VECS[v].lba, 32'd0)));
      check(last_len == VECS[v].len && last_addr == 32'h1000 + 32'(v) * 32'h100,
            "R7", "length and address", 64'(last_len), 64'(VECS[v].len));
      check(last_kind == VECS[v].ekind, "R10", "request kind", 64'(last_kind), 64'(VECS[v].ekind));
      check(seen_done && seen_status == VECS[v].estat, "R5", "completion status",
            64'(seen_status), 64'(VECS[v].estat));
      check(!hold_bad, "R11", "request stable while waiting", 64'(hold_bad), 64'd0);
      check(!active_o, "R5", "active cleared", 64'(active_o), 64'd0);
    end

    // two segments, disk: index carried into second offset
    arm(1'b0, 2'd0, 16'd2, 32'd0, 32'd50);
    run_seg(32'h2000, 32'd512, 1'b0, 0, 1'b0);
    check(!seen_done && active_o, "R1", "bytes left after first segment", 64'(seen_done), 64'd0);
    run_seg(32'h2200, 32'd512, 1'b0, 0, 1'b0);
    check(last_off == exp_offset(1'b0, 32'd50, 32'd512), "R2", "offset with index",
          64'(last_off), 64'(exp_offset(1'b0, 32'd50, 32'd512)));
    check(seen_done && seen_status == 2'd0, "R5", "disk ok", 64'(seen_status), 64'd0);

    // two segments, packet with a count that is not a segment multiple
    arm(1'b1, 2'd0, 16'd0, 32'd3000, 32'd9);
    run_seg(32'h3000, 32'd2048, 1'b0, 1, 1'b0);
    check(!seen_done && active_o, "R1", "packet count loaded", 64'(seen_done), 64'd0);
    run_seg(32'h3800, 32'd2048, 1'b0, 0, 1'b0);
    check(last_off == exp_offset(1'b1, 32'd9, 32'd2048), "R3", "packet offset with index",
          64'(last_off), 64'(exp_offset(1'b1, 32'd9, 32'd2048)));
    check(seen_done && seen_status == 2'd1, "R5", "packet ok", 64'(seen_status), 64'd1);

    // zero-length segment
    arm(1'b0, 2'd0, 16'd1, 32'd0, 32'd77);
    run_seg(32'h4000, 32'd0, 1'b0, 0, 1'b0);
    check(n_req == 0 && !seen_done && active_o, "R6", "zero length closes segment only",
          64'(n_req), 64'd0);
    run_seg(32'h4000, 32'd512, 1'b0, 0, 1'b0);
    check(last_off == exp_offset(1'b0, 32'd77, 32'd0) && seen_done, "R6", "index unchanged",
          64'(last_off), 64'(exp_offset(1'b0, 32'd77, 32'd0)));

    // over-long segment drives count negative, still completes
    arm(1'b0, 2'd0, 16'd1, 32'd0, 32'd4);
    run_seg(32'h5000, 32'd1024, 1'b0, 0, 1'b0);
    check(n_req == 1 && seen_done && seen_status == 2'd0, "R5", "negative count completes",
          64'(seen_status), 64'd0);
    seg_valid_i = 1'b1; seen_busy = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (seg_busy_o || seg_done_o) seen_busy = 1;
    end
    seg_valid_i = 1'b0;
    check(!seen_busy, "R4", "not taken after completion", 64'(seen_busy), 64'd0);

    // zero sector count completes without a request
    arm(1'b0, 2'd0, 16'd0, 32'd0, 32'd4);
    run_seg(32'h5000, 32'd512, 1'b0, 0, 1'b0);
    check(n_req == 0 && seen_done && seen_status == 2'd0, "R5", "empty transfer",
          64'(n_req), 64'd0);

    // non-block packet copy, short and long segments
    arm(1'b1, 2'd0, 16'd0, 32'd100, 32'hFFFF_FFFF);
    run_seg(32'h6000, 32'd64, 1'b0, 0, 1'b0);
    check(last_kind == 2'd3 && last_len == 32'd64, "R8", "copy short", 64'(last_len), 64'd64);
    check(seen_done && seen_status == 2'd1 && !active_o, "R8", "copy completes",
          64'(seen_status), 64'd1);
    arm(1'b1, 2'd0, 16'd0, 32'd100, 32'hFFFF_FFFF);
    run_seg(32'h6100, 32'd300, 1'b0, 2, 1'b0);
    check(last_kind == 2'd3 && last_len == 32'd100 && last_addr == 32'h6100, "R8",
          "copy clipped", 64'(last_len), 64'd100);

    // error on acknowledge
    arm(1'b0, 2'd1, 16'd4, 32'd0, 32'd8);
    run_seg(32'h7000, 32'd512, 1'b1, 1, 1'b0);
    check(seen_sd && seen_done && seen_status == 2'd2 && !active_o, "R9", "error status",
          64'(seen_status), 64'd2);

    // illegal disk command
    arm(1'b0, 2'd3, 16'd1, 32'd0, 32'd8);
    run_seg(32'h7100, 32'd512, 1'b0, 0, 1'b0);
    check(n_req == 0 && seen_done && seen_status == 2'd3, "R10", "illegal command",
          64'(seen_status), 64'd3);

    // start during segment work is ignored
    arm(1'b0, 2'd0, 16'd2, 32'd0, 32'd20);
    run_seg(32'h8000, 32'd512, 1'b0, 3, 1'b1);
    check(!hold_bad, "R11", "held request stable", 64'(hold_bad), 64'd0);
    check(!seen_done && active_o, "R12", "start mid-segment ignored", 64'(seen_done), 64'd0);
    run_seg(32'h8200, 32'd512, 1'b0, 0, 1'b0);
    check(last_off == exp_offset(1'b0, 32'd20, 32'd512) && seen_done, "R12",
          "index kept across ignored start", 64'(last_off), 64'(exp_offset(1'b0, 32'd20, 32'd512)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule